// File: doc/BRIEF.md
# Serial Attenuator Programming Master

This block sits on the host side of a three-wire link (serial data, serial clock, latch enable) and sets the state of addressable step attenuators. A request carries a 3-bit device address and a 7-bit value. The value is used either as a ready-made attenuation code in quarter-dB units, or as a whole number of dB that the block multiplies by four. On acceptance the block builds a 16-bit frame. The low byte is the attenuation code with its top bit cleared. The high byte carries the address in its three low bits and zeros above.

The frame is shifted out least significant bit first. Data changes while the serial clock falls, and latch enable is held low for all sixteen bits. After a setup gap the block pulses latch enable high. It then waits out a holdoff time before it takes the next request, which keeps successive state changes within the device's maximum switching rate. The clock phase length, latch setup, latch width and holdoff are each set by a cycle-count input. A count of zero behaves as one cycle. Requests use a valid/ready handshake, and `busy` is high from acceptance until the end of the holdoff.

Top module: `atten_ser_master`

## Requirements
- R1: The frame, as indexed by the order of transmission, holds the attenuation code in bits 6..0, a zero in bit 7, the request address in bits 10..8 and zeros in bits 15..11; address 3 with code 73 gives 0x0349.
- R2: With `req_whole_db` high the code is `req_value[4:0]` times four and `req_value[6:5]` are ignored; with it low the code is `req_value` unchanged.
- R3: Frame bit k is on `ser_data` at the k-th rising edge of `ser_clk` (bit 0 first), and `ser_data` does not change while `ser_clk` is high.
- R4: Each frame has exactly 16 `ser_clk` pulses. Each low phase (the first one starting at acceptance) and each high phase lasts max(`cfg_half_cycles`,1) clock cycles.
- R5: `ser_le` stays low while bits are shifted and rises max(`cfg_half_cycles`,1)+max(`cfg_setup_cycles`,1) cycles after the last `ser_clk` rising edge.
- R6: `ser_le` stays high for max(`cfg_latch_cycles`,1) cycles and then returns low.
- R7: After `ser_le` falls, `busy` stays high for max(`cfg_holdoff_cycles`,1) cycles. `req_ready` is the inverse of `busy`, and a request held valid while busy is not taken and produces no frame.
- R8: After reset `ser_data`, `ser_clk`, `ser_le` and `busy` are low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_addr | input | 3 | Target device address |
| req_value | input | 7 | Quarter-dB code, or whole dB in bits 4..0 |
| req_whole_db | input | 1 | 1: treat req_value as whole dB |
| cfg_half_cycles | input | 16 | Serial clock phase length in cycles |
| cfg_setup_cycles | input | 16 | Extra gap before the latch pulse |
| cfg_latch_cycles | input | 16 | Latch pulse width in cycles |
| cfg_holdoff_cycles | input | 16 | Quiet time after the latch pulse |
| ser_data | output | 1 | Serial data line |
| ser_clk | output | 1 | Serial clock line |
| ser_le | output | 1 | Latch enable line |
| busy | output | 1 | Frame, latch or holdoff in progress |

## Verification
The serial clock first rises max(H,1) cycles after the accepting edge, and every later phase is also max(H,1) cycles long. The latch rises max(H,1)+max(S,1) cycles after the last clock rise, falls max(W,1) cycles later, and `busy` drops max(D,1) cycles after that. A monitor samples every output on the falling system clock edge. It counts run lengths in samples and compares them against these formulas, using the timing settings stored with each expected frame. Frame bits are captured at each serial clock rise and compared when the latch rises, so a shifted, reordered or stray frame is reported at that edge.

// File: rtl/atten_pkg.sv
package atten_pkg;
  localparam int ADDR_W  = 3;
  localparam int CODE_W  = 7;
  localparam int BYTE_W  = 8;
  localparam int FRAME_W = 2 * BYTE_W;
  localparam int FRAC_W  = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_SETUP,
    ST_LATCH,
    ST_HOLD
  } seq_state_t;
endpackage

// File: rtl/atten_frame_build.sv
module atten_frame_build #(
  parameter int ADDR_W  = 3,
  parameter int CODE_W  = 7,
  parameter int BYTE_W  = 8,
  parameter int FRAC_W  = 2,
  localparam int FRAME_W = 2 * BYTE_W
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic [CODE_W-1:0]  value,
  input  logic               whole_db,
  output logic [FRAME_W-1:0] frame
);
  logic [CODE_W-1:0] code;

  always_comb begin
    if (whole_db) code = {value[CODE_W-FRAC_W-1:0], {FRAC_W{1'b0}}};
    else          code = value;
  end

  // low byte: code, unused top bits zero; high byte: address, rest zero
  always_comb begin
    frame = '0;
    frame[CODE_W-1:0] = code;
    frame[BYTE_W+ADDR_W-1:BYTE_W] = addr;
  end

  // R2: whole-dB requests never carry fractional quarter steps
  always_comb begin
    if (whole_db) begin
      p_whole_frac_r2: assert (frame[FRAC_W-1:0] == '0);
    end
  end
endmodule

// File: rtl/atten_cycle_timer.sv
module atten_cycle_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (load)              cnt_d = load_val;
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
    else                   cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/atten_bit_shifter.sv
module atten_bit_shifter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         shift,
  input  logic [W-1:0] par_in,
  output logic         ser_out
);
  logic [W-1:0] sr_q, sr_d;

  always_comb begin
    if (load)       sr_d = par_in;
    else if (shift) sr_d = {1'b0, sr_q[W-1:1]};
    else            sr_d = sr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  assign ser_out = sr_q[0];
endmodule

// File: rtl/atten_ser_master.sv
module atten_ser_master
  import atten_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CODE_W-1:0] req_value,
  input  logic              req_whole_db,
  input  logic [CNT_W-1:0]  cfg_half_cycles,
  input  logic [CNT_W-1:0]  cfg_setup_cycles,
  input  logic [CNT_W-1:0]  cfg_latch_cycles,
  input  logic [CNT_W-1:0]  cfg_holdoff_cycles,
  output logic              ser_data,
  output logic              ser_clk,
  output logic              ser_le,
  output logic              busy
);
  localparam int BIT_W = $clog2(FRAME_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_W - 1);

  // reset: asserted asynchronously, released through two flops
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  function automatic logic [CNT_W-1:0] span(input logic [CNT_W-1:0] n);
    return (n == '0) ? '0 : n - 1'b1;
  endfunction

  seq_state_t       st_q, st_d;
  logic             ph_q, ph_d;
  logic [BIT_W-1:0] bit_q, bit_d;
  logic             tmr_load, tmr_zero;
  logic [CNT_W-1:0] tmr_val;
  logic             sh_load, sh_shift, sh_out;
  logic [FRAME_W-1:0] frame;

  atten_frame_build #(
    .ADDR_W(ADDR_W), .CODE_W(CODE_W), .BYTE_W(BYTE_W), .FRAC_W(FRAC_W)
  ) u_build (
    .addr(req_addr), .value(req_value), .whole_db(req_whole_db), .frame(frame)
  );

  atten_cycle_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_sync_n), .load(tmr_load), .load_val(tmr_val),
    .zero(tmr_zero)
  );

  atten_bit_shifter #(.W(FRAME_W)) u_shift (
    .clk(clk), .rst_n(rst_sync_n), .load(sh_load), .shift(sh_shift),
    .par_in(frame), .ser_out(sh_out)
  );

  // next-state process
  always_comb begin
    st_d     = st_q;
    ph_d     = ph_q;
    bit_d    = bit_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    sh_load  = 1'b0;
    sh_shift = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          st_d     = ST_SHIFT;
          ph_d     = 1'b0;
          bit_d    = '0;
          sh_load  = 1'b1;
          tmr_load = 1'b1;
          tmr_val  = span(cfg_half_cycles);
        end
      end
      ST_SHIFT: begin
        if (tmr_zero) begin
          tmr_load = 1'b1;
          if (!ph_q) begin
            ph_d    = 1'b1;
            tmr_val = span(cfg_half_cycles);
          end else if (bit_q == LAST_BIT) begin
            st_d    = ST_SETUP;
            ph_d    = 1'b0;
            tmr_val = span(cfg_setup_cycles);
          end else begin
            ph_d     = 1'b0;
            bit_d    = bit_q + 1'b1;
            sh_shift = 1'b1;
            tmr_val  = span(cfg_half_cycles);
          end
        end
      end
      ST_SETUP: begin
        if (tmr_zero) begin
          st_d     = ST_LATCH;
          tmr_load = 1'b1;
          tmr_val  = span(cfg_latch_cycles);
        end
      end
      ST_LATCH: begin
        if (tmr_zero) begin
          st_d     = ST_HOLD;
          tmr_load = 1'b1;
          tmr_val  = span(cfg_holdoff_cycles);
        end
      end
      ST_HOLD: begin
        if (tmr_zero) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      st_q  <= ST_IDLE;
      ph_q  <= 1'b0;
      bit_q <= '0;
    end else begin
      st_q  <= st_d;
      ph_q  <= ph_d;
      bit_q <= bit_d;
    end
  end

  assign ser_clk   = (st_q == ST_SHIFT) & ph_q;
  assign ser_data  = (st_q == ST_SHIFT) & sh_out;
  assign ser_le    = (st_q == ST_LATCH);
  assign busy      = (st_q != ST_IDLE);
  assign req_ready = (st_q == ST_IDLE);

  // R3: shifter output holds while the serial clock is high
  p_data_hold_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ser_clk && $past(ser_clk)) |-> $stable(ser_data));

  // R4: states other than idle are only left when the timer ran out
  p_timer_exit_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((st_q != $past(st_q)) && ($past(st_q) != ST_IDLE)) |-> $past(tmr_zero));

  // R5: latch only rises once the last bit has been sent
  p_le_after_bits_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(ser_le) |-> (bit_q == LAST_BIT));

  // R7: an accepted request starts a frame with the clock low
  p_accept_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && req_ready) |=> (busy && !ser_clk && !ser_le));

  // R7: busy only starts from a valid request
  p_start_on_valid_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(busy) |-> $past(req_valid));
endmodule

// File: tb/tb_atten_ser_master.sv
module tb_atten_ser_master;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk, rst_n;
  logic        req_valid, req_ready, req_whole_db;
  logic [2:0]  req_addr;
  logic [6:0]  req_value;
  logic [15:0] cfg_h, cfg_s, cfg_w, cfg_d;
  logic        ser_data, ser_clk, ser_le, busy;

  atten_ser_master dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_value(req_value), .req_whole_db(req_whole_db),
    .cfg_half_cycles(cfg_h), .cfg_setup_cycles(cfg_s),
    .cfg_latch_cycles(cfg_w), .cfg_holdoff_cycles(cfg_d),
    .ser_data(ser_data), .ser_clk(ser_clk), .ser_le(ser_le), .busy(busy)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic [15:0] frame;
    int h, s, w, d;
    string tag;
  } exp_t;

  exp_t q[$];
  int total = 0, bad = 0, frames_seen = 0, frames_sent = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int eff(input int n);
    return (n == 0) ? 1 : n;
  endfunction

  function automatic logic [15:0] exp_frame(input logic [2:0] a, input logic [6:0] v,
                                            input logic w);
    logic [6:0] code;
    code = w ? {v[4:0], 2'b00} : v;
    return {5'b00000, a, 1'b0, code};
  endfunction

  // monitor: sample on falling system clock edge
  logic prev_clk, prev_le, prev_busy, prev_data;
  logic [15:0] cap;
  int nbits, low_len, high_len, since_rise, le_len, hold_len;
  bit in_hold;
  exp_t cur;

  always @(negedge clk) begin
    if (!rst_n) begin
      prev_clk = 0; prev_le = 0; prev_busy = 0; prev_data = 0;
      nbits = 0; low_len = 0; high_len = 0; since_rise = 0;
      le_len = 0; hold_len = 0; in_hold = 0; cap = '0;
    end else begin
      if (busy && !prev_busy) begin
        nbits = 0; low_len = 0; cap = '0; in_hold = 0;
        if (q.size() > 0) cur = q[0];
        else begin
          chk(0, "R7 frame started with no request", 1, 0);
          cur.h = 0; cur.s = 0; cur.w = 0; cur.d = 0; cur.frame = '0; cur.tag = "R7";
        end
      end
      if (ser_clk && !prev_clk) begin
        chk(low_len == eff(cur.h), "R4 low phase length", low_len, eff(cur.h));
        chk(!ser_le, "R5 latch low during shift", ser_le, 0);
        if (nbits < 16) cap[nbits] = ser_data;
        nbits++;
        since_rise = 0;
        high_len = 1;
      end else begin
        since_rise++;
        if (ser_clk) begin
          high_len++;
          chk(ser_data == prev_data, "R3 data stable while clock high", ser_data, prev_data);
        end
        if (!ser_clk && prev_clk) begin
          chk(high_len == eff(cur.h), "R4 high phase length", high_len, eff(cur.h));
          low_len = 0;
        end
      end
      if (busy && !ser_clk && !ser_le && nbits < 16) low_len++;

      if (ser_le && !prev_le) begin
        frames_seen++;
        chk(nbits == 16, "R4 clock pulses per frame", nbits, 16);
        chk(since_rise == eff(cur.h) + eff(cur.s), "R5 latch setup", since_rise,
            eff(cur.h) + eff(cur.s));
        chk(req_ready == 0, "R7 ready low while busy", req_ready, 0);
        if (q.size() > 0) begin
          exp_t e;
          e = q.pop_front();
          chk(cap == e.frame, {e.tag, " frame content"}, cap, e.frame);
        end else begin
          chk(0, "R7 unexpected latch", 1, 0);
        end
        le_len = 0;
      end
      if (ser_le) le_len++;
      if (!ser_le && prev_le) begin
        chk(le_len == eff(cur.w), "R6 latch width", le_len, eff(cur.w));
        hold_len = 0;
        in_hold = 1;
      end
      if (in_hold && busy && !ser_le) hold_len++;
      if (!busy && prev_busy) begin
        chk(hold_len == eff(cur.d), "R7 holdoff length", hold_len, eff(cur.d));
        chk(req_ready == 1, "R7 ready back when idle", req_ready, 1);
        in_hold = 0;
      end
      prev_clk = ser_clk; prev_le = ser_le; prev_busy = busy; prev_data = ser_data;
    end
  end

  task automatic send(input logic [2:0] a, input logic [6:0] v, input logic w,
                      input string tag);
    exp_t e;
    e.frame = exp_frame(a, v, w);
    e.h = int'(cfg_h); e.s = int'(cfg_s); e.w = int'(cfg_w); e.d = int'(cfg_d);
    e.tag = tag;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    q.push_back(e);
    frames_sent++;
    req_valid = 1; req_addr = a; req_value = v; req_whole_db = w;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy || q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    rst_n = 0; req_valid = 0; req_addr = 0; req_value = 0; req_whole_db = 0;
    cfg_h = 2; cfg_s = 1; cfg_w = 3; cfg_d = 4;
    repeat (4) @(negedge clk);
    // R8: reset state
    chk(!ser_clk && !ser_data && !ser_le, "R8 serial lines low in reset",
        {ser_clk, ser_data, ser_le}, 0);
    chk(!busy, "R8 busy low in reset", busy, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk(!ser_clk && !ser_data && !ser_le && !busy, "R8 idle after reset",
        {ser_clk, ser_data, ser_le, busy}, 0);
    chk(req_ready, "R8 ready after reset", req_ready, 1);

    // R1: worked example, boundaries and empty code
    send(3'd3, 7'd73, 1'b0, "R1");
    send(3'd7, 7'd127, 1'b0, "R1");
    send(3'd0, 7'd0, 1'b0, "R1");
    // R2: whole-dB input, upper bits ignored
    send(3'd5, 7'b1100101, 1'b1, "R2");
    send(3'd2, 7'd31, 1'b1, "R2");
    wait_idle();

    // zero counts behave as one cycle
    cfg_h = 0; cfg_s = 0; cfg_w = 0; cfg_d = 0;
    send(3'd6, 7'd85, 1'b0, "R1");
    send(3'd1, 7'b0011111, 1'b0, "R2");
    wait_idle();

    // longer timing plus a request held valid while busy
    cfg_h = 5; cfg_s = 3; cfg_w = 2; cfg_d = 6;
    send(3'd1, 7'd42, 1'b0, "R1");
    @(negedge clk);
    while (!ser_le) @(negedge clk);
    req_valid = 1; req_addr = 3'd4; req_value = 7'd9; req_whole_db = 0;
    while (ser_le) @(negedge clk);
    req_valid = 0;
    wait_idle();
    repeat (20) @(negedge clk);
    chk(!busy && !ser_le, "R7 request while busy ignored", {busy, ser_le}, 0);
    chk(frames_seen == frames_sent, "R7 frame count", frames_seen, frames_sent);

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", WATCHDOG, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule